// File: doc/BRIEF.md
# Windowed Watchdog with System Enable

This block supervises a microcontroller through its trigger pin. Time is measured in ticks of a shared cycle strobe. After each start, the block runs a closed window, during which servicing is forbidden. An open window follows, during which the controller must service the watchdog. The trigger pin is not edge-detected. It is read once per tick, and a service counts only when four consecutive readings form high, high, low, low.

A service that completes too early, or no service before the open window runs out, is a fault. A fault schedules a reset request at a fixed tick offset from the most recent window-sequence start. The request is held for a fixed number of ticks, and then the sequence begins again. A system-enable output rises on the first correct service. It drops on a fault or when the power-on supervisor reports the supply as not good. The reset request is merged with the power-on state into an active-low system reset.

Top module: `win_watchdog`

## Requirements
- R1: After reset release, after power-good returns, and after each watchdog reset, a closed window of CW_CYCLES ticks runs first. A trigger completing on any of those ticks is a pretrigger fault.
- R2: The trigger pin is sampled only in clock cycles where `cyc_tick` is high. Its level in other cycles has no effect.
- R3: A valid trigger is four consecutive samples equal to 1,1,0,0, oldest first. A shorter high pulse (1,0,0,...) is not a trigger.
- R4: A pattern whose first three samples fall in the closed window and whose fourth sample falls on the first open-window tick is a valid trigger.
- R5: The open window lasts up to OW_CYCLES ticks. A valid trigger on any of its ticks, including the last, starts a new closed window at once.
- R6: If the open window reaches OW_CYCLES ticks with no valid trigger, a missing-trigger fault occurs.
- R7: After a fault, `wd_rst_req` goes high on the tick that is FAULT_DELAY ticks after the latest window-sequence start. It stays high for RESET_CYCLES ticks. `sys_rst_n` equals `por_ok` and not `wd_rst_req`.
- R8: Trigger samples taken between a fault and the end of its reset request have no effect on reset timing or on `sys_en`.
- R9: `sys_en` rises in the clock after the tick that completes the first valid trigger.
- R10: `sys_en` falls in the clock after the tick that detects a pretrigger or a missing trigger.
- R11: While `por_ok` is low, `sys_en` and `wd_rst_req` are low from the next clock on, and the window state and the sample history are cleared.
- R12: Synchronous `rst` leaves `sys_en` low, `wd_rst_req` low and the sequence at a closed-window start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-clock strobe marking each watchdog cycle |
| trig_in | input | 1 | Synchronised trigger pin from the controller |
| por_ok | input | 1 | Power-on supervisor state, high when supply is good |
| wd_rst_req | output | 1 | Watchdog reset request |
| sys_rst_n | output | 1 | Combined active-low system reset |
| sys_en | output | 1 | System enable |

## Verification
The bench builds the block with windows of 4 closed and 6 open ticks, a fault delay of 12 ticks and a reset length of 5 ticks. The tick arrives every third clock. With these values, each window edge, the fault delay measured from a pretrigger and from a missing trigger, and the full reset length can be reached in a few dozen ticks. The clocks between ticks carry trigger glitches that must be ignored.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    localparam int unsigned SMP_DEPTH = 4;
    localparam logic [SMP_DEPTH-1:0] TRIG_SHAPE = 4'b1100;

    typedef enum logic [1:0] {
        PH_CLOSED = 2'd0,
        PH_OPEN   = 2'd1,
        PH_HOLD   = 2'd2,
        PH_RESET  = 2'd3
    } wdw_phase_e;

    typedef struct packed {
        logic valid;
        logic pre;
        logic miss;
    } wdw_evt_s;

    function automatic logic shape_match(logic [SMP_DEPTH-1:0] h);
        return h == TRIG_SHAPE;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wdw_sampler.sv
module wdw_sampler
    import wdw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic din,
    input  logic clr,
    output logic hit
);

    logic [SMP_DEPTH-1:0] hist_q;
    logic [SMP_DEPTH-1:0] hist_nx;

    always_comb begin
        hist_nx = {hist_q[SMP_DEPTH-2:0], din};
        hit     = tick && !clr && shape_match(hist_nx);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist_q <= '0;
        end else if (tick) begin
            hist_q <= hit ? '0 : hist_nx;
        end
    end

    // R2: history moves only on a tick
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(hist_q));

    // R3: a completed trigger empties the history
    a_r3_hit_clears: assert property (@(posedge clk) disable iff (rst)
        hit |=> (hist_q == '0));

endmodule

// File: rtl/wdw_seq.sv
module wdw_seq
    import wdw_pkg::*;
#(
    parameter int unsigned CW_CYCLES    = 32,
    parameter int unsigned OW_CYCLES    = 32,
    parameter int unsigned FAULT_DELAY  = 64,
    parameter int unsigned RESET_CYCLES = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     por_ok,
    input  logic     tick,
    input  logic     hit,
    output wdw_evt_s evt_o,
    output logic     smp_clr,
    output logic     wd_rst_o
);

    localparam int unsigned WMAX = max3(CW_CYCLES, OW_CYCLES, RESET_CYCLES);
    localparam int unsigned WW   = $clog2(WMAX + 1);
    localparam int unsigned SW   = $clog2(FAULT_DELAY + 1);
    localparam logic [WW-1:0] CW_L  = WW'(CW_CYCLES);
    localparam logic [WW-1:0] OW_L  = WW'(OW_CYCLES);
    localparam logic [WW-1:0] WDR_L = WW'(RESET_CYCLES);
    localparam logic [SW-1:0] SR_L  = SW'(FAULT_DELAY);

    wdw_phase_e    phase_q;
    logic [WW-1:0] wcnt_q;
    logic [SW-1:0] scnt_q;
    logic [WW-1:0] wnext;
    logic [SW-1:0] snext;

    always_comb begin
        wnext       = wcnt_q + 1'b1;
        snext       = scnt_q + 1'b1;
        evt_o.pre   = tick && (phase_q == PH_CLOSED) && hit;
        evt_o.valid = tick && (phase_q == PH_OPEN) && hit;
        evt_o.miss  = tick && (phase_q == PH_OPEN) && !hit && (wnext == OW_L);
        smp_clr     = !por_ok || (phase_q == PH_HOLD) || (phase_q == PH_RESET);
        wd_rst_o    = (phase_q == PH_RESET);
    end

    always_ff @(posedge clk) begin
        if (rst || !por_ok) begin
            phase_q <= PH_CLOSED;
            wcnt_q  <= '0;
            scnt_q  <= '0;
        end else if (tick) begin
            unique case (phase_q)
                PH_CLOSED: begin
                    scnt_q <= snext;
                    if (hit) begin
                        phase_q <= (snext == SR_L) ? PH_RESET : PH_HOLD;
                        wcnt_q  <= '0;
                    end else if (wnext == CW_L) begin
                        phase_q <= PH_OPEN;
                        wcnt_q  <= '0;
                    end else begin
                        wcnt_q  <= wnext;
                    end
                end
                PH_OPEN: begin
                    if (hit) begin
                        phase_q <= PH_CLOSED;
                        wcnt_q  <= '0;
                        scnt_q  <= '0;
                    end else if (wnext == OW_L) begin
                        phase_q <= (snext == SR_L) ? PH_RESET : PH_HOLD;
                        wcnt_q  <= '0;
                        scnt_q  <= snext;
                    end else begin
                        wcnt_q  <= wnext;
                        scnt_q  <= snext;
                    end
                end
                PH_HOLD: begin
                    scnt_q <= snext;
                    if (snext == SR_L) begin
                        phase_q <= PH_RESET;
                        wcnt_q  <= '0;
                    end
                end
                PH_RESET: begin
                    if (wnext == WDR_L) begin
                        phase_q <= PH_CLOSED;
                        wcnt_q  <= '0;
                        scnt_q  <= '0;
                    end else begin
                        wcnt_q  <= wnext;
                    end
                end
                default: phase_q <= PH_CLOSED;
            endcase
        end
    end

    // R5: a valid trigger starts a fresh closed window
    a_r5_valid_restart: assert property (@(posedge clk) disable iff (rst)
        (evt_o.valid && por_ok) |=> (phase_q == PH_CLOSED && scnt_q == '0));

    // R8: no trigger is recognised while a fault is pending or served
    a_r8_quiet_in_fault: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD || phase_q == PH_RESET) |-> !hit);

    // R7: the reset request holds between ticks
    a_r7_rst_hold: assert property (@(posedge clk) disable iff (rst)
        (wd_rst_o && !tick && por_ok) |=> wd_rst_o);

endmodule

// File: rtl/wdw_enable.sv
module wdw_enable
    import wdw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     por_ok,
    input  logic     wd_rst,
    input  wdw_evt_s evt,
    output logic     sys_en
);

    logic en_q;

    always_ff @(posedge clk) begin
        if (rst || !por_ok || wd_rst || evt.pre || evt.miss) begin
            en_q <= 1'b0;
        end else if (evt.valid) begin
            en_q <= 1'b1;
        end
    end

    assign sys_en = en_q;

    // R9: enable only rises after a valid trigger
    a_r9_rise_on_valid: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $past(evt.valid));

    // R10: faults drop the enable in the next clock
    a_r10_fault_drop: assert property (@(posedge clk) disable iff (rst)
        (evt.pre || evt.miss) |=> !en_q);

    // R11: supply loss drops the enable
    a_r11_por_drop: assert property (@(posedge clk) disable iff (rst)
        !por_ok |=> !en_q);

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wdw_pkg::*;
#(
    parameter int unsigned CW_CYCLES    = 32,
    parameter int unsigned OW_CYCLES    = 32,
    parameter int unsigned FAULT_DELAY  = 64,
    parameter int unsigned RESET_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_tick,
    input  logic trig_in,
    input  logic por_ok,
    output logic wd_rst_req,
    output logic sys_rst_n,
    output logic sys_en
);

    wdw_evt_s evt;
    logic     hit;
    logic     smp_clr;
    logic     wd_rst;

    wdw_sampler u_smp (
        .clk  (clk),
        .rst  (rst),
        .tick (cyc_tick),
        .din  (trig_in),
        .clr  (smp_clr),
        .hit  (hit)
    );

    wdw_seq #(
        .CW_CYCLES    (CW_CYCLES),
        .OW_CYCLES    (OW_CYCLES),
        .FAULT_DELAY  (FAULT_DELAY),
        .RESET_CYCLES (RESET_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .por_ok   (por_ok),
        .tick     (cyc_tick),
        .hit      (hit),
        .evt_o    (evt),
        .smp_clr  (smp_clr),
        .wd_rst_o (wd_rst)
    );

    wdw_enable u_en (
        .clk    (clk),
        .rst    (rst),
        .por_ok (por_ok),
        .wd_rst (wd_rst),
        .evt    (evt),
        .sys_en (sys_en)
    );

    assign wd_rst_req = wd_rst;
    assign sys_rst_n  = por_ok & ~wd_rst;

    // R6: one outcome per tick at most
    a_r6_single_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.valid, evt.pre, evt.miss}));

    // R7: enable never coexists with a reset request
    a_r7_no_en_in_reset: assert property (@(posedge clk) disable iff (rst)
        wd_rst_req |-> !sys_en);

    // R11: no watchdog request after supply loss
    a_r11_por_clears_req: assert property (@(posedge clk) disable iff (rst)
        !por_ok |=> !wd_rst_req);

endmodule

// File: tb/win_watchdog_tb_top.sv
`timescale 1ns/1ps
module win_watchdog_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_tick = 1'b0;
    logic trig_in = 1'b0;
    logic por_ok = 1'b1;
    logic wd_rst_req, sys_rst_n, sys_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    win_watchdog #(
        .CW_CYCLES(4), .OW_CYCLES(6), .FAULT_DELAY(12), .RESET_CYCLES(5)
    ) dut_i (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .trig_in(trig_in),
        .por_ok(por_ok), .wd_rst_req(wd_rst_req), .sys_rst_n(sys_rst_n), .sys_en(sys_en)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // one watchdog cycle: tick with the given sample, then two idle clocks
    task automatic step(input logic v);
        @(negedge clk); trig_in = v; cyc_tick = 1'b1;
        @(negedge clk); cyc_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic steps(input logic [15:0] pat, input int n);
        for (int i = n - 1; i >= 0; i--) step(pat[i]);
    endtask

    task automatic t_reset;
        rst = 1'b1; por_ok = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 sys_en", sys_en, 1'b0);
        chk("R12 wd_rst_req", wd_rst_req, 1'b0);
        chk("R12 sys_rst_n", sys_rst_n, 1'b1);
    endtask

    task automatic t_first_valid;
        steps(16'b0000, 4);
        steps(16'b110, 3);
        chk("R9 sys_en before completion", sys_en, 1'b0);
        step(1'b0);
        chk("R9 sys_en after first valid", sys_en, 1'b1);
        chk("R5 no reset", wd_rst_req, 1'b0);
    endtask

    task automatic t_straddle;
        steps(16'b0110, 4);
        chk("R4 no pretrigger on three samples", sys_en, 1'b1);
        step(1'b0);
        steps(16'b0000_1100, 8);
        chk("R4 straddle valid, sys_en", sys_en, 1'b1);
        chk("R4 straddle valid, no reset", wd_rst_req, 1'b0);
    endtask

    task automatic t_last_open;
        steps(16'b0000, 4);
        steps(16'b001100, 6);
        chk("R5 valid on last open tick", sys_en, 1'b1);
        chk("R5 no reset", wd_rst_req, 1'b0);
    endtask

    task automatic t_pretrigger;
        steps(16'b110, 3);
        chk("R1 still enabled", sys_en, 1'b1);
        step(1'b0);
        chk("R10 pretrigger drops sys_en", sys_en, 1'b0);
        chk("R1 reset not yet", wd_rst_req, 1'b0);
        steps(16'b1100_000, 7);
        chk("R8 ignored trigger keeps sys_en low", sys_en, 1'b0);
        chk("R7 reset not before delay", wd_rst_req, 1'b0);
        step(1'b0);
        chk("R7 reset at delay", wd_rst_req, 1'b1);
        chk("R7 sys_rst_n low", sys_rst_n, 1'b0);
        steps(16'b1100, 4);
        chk("R7 reset still held", wd_rst_req, 1'b1);
        step(1'b0);
        chk("R7 reset released after length", wd_rst_req, 1'b0);
        chk("R8 trigger in reset ignored", sys_en, 1'b0);
        chk("R7 sys_rst_n high", sys_rst_n, 1'b1);
    endtask

    task automatic t_missing;
        steps(16'b0000_1100, 8);
        chk("R1 valid after reset restart", sys_en, 1'b1);
        steps(16'b0000, 4);
        for (int g = 0; g < 2; g++) begin
            @(negedge clk); trig_in = 1'b1;
            @(negedge clk); trig_in = 1'b1;
            @(negedge clk); trig_in = 1'b0;
            @(negedge clk); trig_in = 1'b0;
        end
        steps(16'b10000, 5);
        chk("R2 R3 glitch and short pulse ignored", sys_en, 1'b1);
        step(1'b0);
        chk("R6 missing trigger drops sys_en", sys_en, 1'b0);
        step(1'b0);
        chk("R6 reset not before delay", wd_rst_req, 1'b0);
        step(1'b0);
        chk("R6 reset at delay", wd_rst_req, 1'b1);
        steps(16'b00000, 5);
        chk("R7 release after missing-trigger reset", wd_rst_req, 1'b0);
    endtask

    task automatic t_por;
        steps(16'b0000_1100, 8);
        chk("R9 enabled before supply loss", sys_en, 1'b1);
        steps(16'b11, 2);
        @(negedge clk); por_ok = 1'b0;
        @(negedge clk);
        chk("R11 sys_en low", sys_en, 1'b0);
        chk("R11 sys_rst_n low", sys_rst_n, 1'b0);
        chk("R11 wd_rst_req low", wd_rst_req, 1'b0);
        step(1'b0);
        chk("R11 ticks ignored while supply bad", sys_en, 1'b0);
        por_ok = 1'b1;
        @(negedge clk);
        steps(16'b0000_1100, 8);
        chk("R11 fresh sequence after supply return", sys_en, 1'b1);
        chk("R11 no reset", wd_rst_req, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_valid();
        t_straddle();
        t_last_open();
        t_pretrigger();
        t_missing();
        t_por();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule